// File: doc/BRIEF.md
# Scanline Bus Slot Arbiter

This block shares one 16-bit memory bus among several requesters by handing out time slots at fixed places along each scanline. The block runs on the CPU clock, and each bus slot lasts two of those clocks. A line lasts 455 clocks, which is 227.5 slots. Only the first 226 slots can be given to DMA. The remaining three clocks are a tail that belongs to the CPU alone.

Refresh, disk, audio and sprite channels each own a short run of slot positions, set by parameters. Bitplane fetch claims slots inside a window that is set at run time. When fetch is enabled, that window overrides every other owner. In high resolution the window is cut into groups of four slots, and in low resolution into groups of eight. If an owner does not ask for its slot, the slot passes down the priority chain: display-list engine first, then blitter, then CPU.

Each clock the block returns a grant vector with at most one bit set. It also returns the ordinal of the granted slot within its channel, the plane being fetched, the slot index, a flag that marks grantable slots, and a pulse on the first clock of each line. Grant bits are numbered 0 CPU, 1 blitter, 2 display-list, 3 refresh, 4 disk, 5 audio, 6 sprite, 7 bitplane.

Top module: `scan_slot_arbiter`

## Requirements
- R1: A line is 455 clocks. `slot_idx` equals the clock position within the line divided by two, so it runs 0..227 and holds for two clocks. `line_start` is high only on clock 0 of each line.
- R2: `slot_live` is high for slots 0..225 and low for the 3-clock tail. In the tail, only grant bit 0 (CPU) may be set, and it is set when `req_cpu` is high.
- R3: The grant vector never has more than one bit set.
- R4: Fixed slots use these defaults: refresh at 1,3,5,7; disk at 9,10,11; audio at 13,15,17,19; sprites at 21,23,...,51. If the owner requests, it gets the slot and `chan_idx` gives the slot's ordinal within its channel (sprite number = ordinal/2). Per line this gives 4, 3, 4 and 16 grants.
- R5: A fixed slot that its owner does not request goes to the display-list engine, the blitter or the CPU, in that order.
- R6: In high resolution with `bpl_en` set, a slot s in [`win_start`,`win_stop`) with p = (s-`win_start`) mod 4 goes to bitplane when p < `planes`. `plane_idx` is p.
- R7: In low resolution, with q = (s-`win_start`) mod 8, the plane is q/2 for odd q and 4+q/2 for even q. The slot goes to bitplane when that plane < `planes`, and `plane_idx` shows it.
- R8: A bitplane slot beats every other requester, including fixed owners whose slots fall inside the window.
- R9: A slot with no fixed or bitplane claim goes to the display-list engine, otherwise the blitter, otherwise the CPU. The CPU never wins while either of the others requests.
- R10: Over a line, bitplane grants equal (window slots / group size) × planes. For example, a 160-slot high-resolution window with 4 planes gives 160 grants, and in low resolution it gives 80.
- R11: After reset, the line starts at clock 0: `slot_idx` is 0, `line_start` is high, and nothing is granted without requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | synchronous active-low reset |
| req_refresh | input | 1 | refresh wants its slots |
| req_disk | input | 1 | disk wants its slots |
| req_audio | input | 1 | audio wants its slots |
| req_sprite | input | 1 | sprite fetch wants its slots |
| req_dlist | input | 1 | display-list engine request |
| req_blit | input | 1 | blitter request |
| req_cpu | input | 1 | CPU request |
| bpl_en | input | 1 | bitplane fetch enable |
| hires | input | 1 | 1 = 4-slot groups, 0 = 8-slot groups |
| planes | input | 3 | number of active planes |
| win_start | input | 8 | first slot of fetch window |
| win_stop | input | 8 | slot after the last window slot |
| grant | output | 8 | one-hot grant, bit order as above |
| chan_idx | output | 4 | ordinal inside the fixed channel granted |
| plane_idx | output | 3 | plane fetched in this slot |
| slot_idx | output | 8 | current slot number |
| slot_live | output | 1 | slot may be granted to DMA |
| line_start | output | 1 | first clock of a line |

## Verification
The assertions assume three things about the inputs. The fetch window satisfies `win_start` ≤ `win_stop` ≤ 226. `planes` stays within 4 in high resolution and within 6 in low resolution. The fixed channels' parameter positions never overlap. The stimulus sets configuration only through these legal values and lets request lines change on any clock, including long pseudo-random stretches. One configuration places the window over the sprite slots so that bitplane priority can be observed.

// File: rtl/slot_arb_pkg.sv
// Shared constants for the scanline slot arbiter: grant bit positions and field widths.
package slot_arb_pkg;
    localparam int SRC_N       = 8;
    localparam int SRC_CPU     = 0;
    localparam int SRC_BLIT    = 1;
    localparam int SRC_DLIST   = 2;
    localparam int SRC_REFRESH = 3;
    localparam int SRC_DISK    = 4;
    localparam int SRC_AUDIO   = 5;
    localparam int SRC_SPRITE  = 6;
    localparam int SRC_BPL     = 7;
    localparam int FIX_N       = 4;
    localparam int PL_W        = 3;
endpackage

// File: rtl/slot_timer.sv
// Line timer: counts CPU clocks within a line and derives the slot number.
// Assumes LINE_CLKS is odd-length tail friendly, i.e. 2*GRANT_SLOTS < LINE_CLKS.
module slot_timer #(
    parameter int LINE_CLKS   = 455,
    parameter int GRANT_SLOTS = 226,
    parameter int SLOT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_live,
    output logic              line_start
);
    localparam int CYC_W = $clog2(LINE_CLKS);
    localparam logic [CYC_W-1:0] LAST = CYC_W'(LINE_CLKS - 1);
    localparam logic [CYC_W-1:0] LIVE_END = CYC_W'(2 * GRANT_SLOTS);

    logic [CYC_W-1:0] cyc;

    // Clock position within the line, wrapping at the line length.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc == LAST) cyc <= '0;
        else                 cyc <= cyc + 1'b1;
    end

    // Slot number, grantable flag and line marker from the clock position.
    always_comb begin
        slot_idx   = SLOT_W'(cyc >> 1);
        slot_live  = (cyc < LIVE_END);
        line_start = (cyc == '0);
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc[0] && cyc != LAST) |=> $stable(slot_idx)); // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cyc[0] |=> (slot_idx == $past(slot_idx) + 1'b1)); // R1
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == LAST) |=> (line_start && slot_idx == '0)); // R1
endmodule

// File: rtl/slot_region.sv
// Decodes whether a slot falls on one fixed channel's positions: COUNT slots
// starting at FIRST, spaced STEP apart. Gives the ordinal of the hit.
module slot_region #(
    parameter int FIRST  = 1,
    parameter int COUNT  = 4,
    parameter int STEP   = 2,
    parameter int SLOT_W = 8,
    parameter int CHAN_W = 4
) (
    input  logic [SLOT_W-1:0] slot,
    output logic              hit,
    output logic [CHAN_W-1:0] ord
);
    localparam int SPAN = COUNT * STEP;

    logic [SLOT_W-1:0] off;

    // Position test against the parameterised run of slots.
    always_comb begin
        off = slot - SLOT_W'(FIRST);
        hit = (slot >= SLOT_W'(FIRST)) && (off < SLOT_W'(SPAN))
              && ((off % SLOT_W'(STEP)) == '0);
        ord = CHAN_W'(off / SLOT_W'(STEP));
    end
endmodule

// File: rtl/plane_fetch.sv
// Bitplane slot decoder: inside the fetch window, maps each slot to a plane
// using 4-slot groups (high resolution) or 8-slot interleaved groups (low).
// Assumes win_start <= win_stop.
module plane_fetch
    import slot_arb_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              slot_live,
    input  logic [SLOT_W-1:0] slot,
    input  logic              bpl_en,
    input  logic              hires,
    input  logic [PL_W-1:0]   planes,
    input  logic [SLOT_W-1:0] win_start,
    input  logic [SLOT_W-1:0] win_stop,
    output logic              fetch,
    output logic [PL_W-1:0]   plane
);
    logic [2:0] pos;
    logic       in_win;

    // Group position, plane mapping per resolution, and the fetch decision.
    always_comb begin
        pos    = slot[2:0] - win_start[2:0];
        in_win = bpl_en && slot_live && (slot >= win_start) && (slot < win_stop);
        if (hires)       plane = {1'b0, pos[1:0]};
        else if (pos[0]) plane = {1'b0, pos[2:1]};
        else             plane = {1'b1, pos[2:1]};
        fetch = in_win && (plane < planes);
    end
endmodule

// File: rtl/scan_slot_arbiter.sv
// Scanline slot arbiter: grants one bus slot per two CPU clocks by position in
// the line. Bitplane window first, then fixed channels, then display-list,
// blitter, CPU. Assumes fixed channel positions do not overlap each other.
module scan_slot_arbiter
    import slot_arb_pkg::*;
#(
    parameter int LINE_CLKS     = 455,
    parameter int GRANT_SLOTS   = 226,
    parameter int SLOT_W        = 8,
    parameter int CHAN_W        = 4,
    parameter int REFRESH_FIRST = 1,
    parameter int REFRESH_NUM   = 4,
    parameter int REFRESH_STEP  = 2,
    parameter int DISK_FIRST    = 9,
    parameter int DISK_NUM      = 3,
    parameter int DISK_STEP     = 1,
    parameter int AUDIO_FIRST   = 13,
    parameter int AUDIO_NUM     = 4,
    parameter int AUDIO_STEP    = 2,
    parameter int SPRITE_FIRST  = 21,
    parameter int SPRITE_NUM    = 16,
    parameter int SPRITE_STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_refresh,
    input  logic              req_disk,
    input  logic              req_audio,
    input  logic              req_sprite,
    input  logic              req_dlist,
    input  logic              req_blit,
    input  logic              req_cpu,
    input  logic              bpl_en,
    input  logic              hires,
    input  logic [PL_W-1:0]   planes,
    input  logic [SLOT_W-1:0] win_start,
    input  logic [SLOT_W-1:0] win_stop,
    output logic [SRC_N-1:0]  grant,
    output logic [CHAN_W-1:0] chan_idx,
    output logic [PL_W-1:0]   plane_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_live,
    output logic              line_start
);
    localparam int FIX_FIRST [FIX_N] = '{REFRESH_FIRST, DISK_FIRST, AUDIO_FIRST, SPRITE_FIRST};
    localparam int FIX_NUM   [FIX_N] = '{REFRESH_NUM, DISK_NUM, AUDIO_NUM, SPRITE_NUM};
    localparam int FIX_STEP  [FIX_N] = '{REFRESH_STEP, DISK_STEP, AUDIO_STEP, SPRITE_STEP};

    logic [FIX_N-1:0]  fix_hit;
    logic [FIX_N-1:0]  fix_req;
    logic [CHAN_W-1:0] fix_ord [FIX_N];
    logic              fetch;
    logic [PL_W-1:0]   fetch_plane;
    logic              owned;

    slot_timer #(.LINE_CLKS(LINE_CLKS), .GRANT_SLOTS(GRANT_SLOTS), .SLOT_W(SLOT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx),
        .slot_live(slot_live), .line_start(line_start)
    );

    plane_fetch #(.SLOT_W(SLOT_W)) u_fetch (
        .slot_live(slot_live), .slot(slot_idx), .bpl_en(bpl_en), .hires(hires),
        .planes(planes), .win_start(win_start), .win_stop(win_stop),
        .fetch(fetch), .plane(fetch_plane)
    );

    // One position decoder per fixed channel.
    for (genvar k = 0; k < FIX_N; k++) begin : g_fix
        slot_region #(.FIRST(FIX_FIRST[k]), .COUNT(FIX_NUM[k]), .STEP(FIX_STEP[k]),
                      .SLOT_W(SLOT_W), .CHAN_W(CHAN_W)) u_region (
            .slot(slot_idx), .hit(fix_hit[k]), .ord(fix_ord[k])
        );
    end

    assign fix_req = {req_sprite, req_audio, req_disk, req_refresh};

    // Priority resolution for the current slot.
    always_comb begin
        grant     = '0;
        chan_idx  = '0;
        plane_idx = '0;
        owned     = 1'b0;
        if (!slot_live) begin
            grant[SRC_CPU] = req_cpu;
        end else if (fetch) begin
            grant[SRC_BPL] = 1'b1;
            plane_idx      = fetch_plane;
        end else begin
            for (int k = 0; k < FIX_N; k++) begin
                if (fix_hit[k] && fix_req[k]) begin
                    grant[SRC_REFRESH + k] = 1'b1;
                    chan_idx = fix_ord[k];
                    owned    = 1'b1;
                end
            end
            if (!owned) begin
                if (req_dlist)     grant[SRC_DLIST] = 1'b1;
                else if (req_blit) grant[SRC_BLIT]  = 1'b1;
                else               grant[SRC_CPU]   = req_cpu;
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R3
    AST_TAIL_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_live |-> (grant[SRC_N-1:1] == '0)); // R2
    AST_BPL_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        grant[SRC_BPL] |-> (bpl_en && slot_idx >= win_start && slot_idx < win_stop)); // R6
    AST_CPU_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_live && grant[SRC_CPU]) |-> (req_cpu && !req_dlist && !req_blit)); // R9
    AST_REFRESH_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        grant[SRC_REFRESH] |-> (slot_idx[0] && req_refresh)); // R4
endmodule

// File: tb/scan_slot_arbiter_test.sv
`timescale 1ns/1ps
module scan_slot_arbiter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_refresh = 0, req_disk = 0, req_audio = 0, req_sprite = 0;
    logic req_dlist = 0, req_blit = 0, req_cpu = 0;
    logic bpl_en = 0, hires = 0;
    logic [2:0] planes = 0;
    logic [7:0] win_start = 0, win_stop = 0;
    logic [7:0] grant;
    logic [3:0] chan_idx;
    logic [2:0] plane_idx;
    logic [7:0] slot_idx;
    logic slot_live, line_start;

    int checks = 0, errors = 0, mcyc = 0, ticks = 0;
    int cnt [8];
    int tail_cpu = 0;
    bit counting = 0, rnd = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    scan_slot_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_refresh(req_refresh), .req_disk(req_disk),
        .req_audio(req_audio), .req_sprite(req_sprite), .req_dlist(req_dlist),
        .req_blit(req_blit), .req_cpu(req_cpu), .bpl_en(bpl_en), .hires(hires),
        .planes(planes), .win_start(win_start), .win_stop(win_stop), .grant(grant),
        .chan_idx(chan_idx), .plane_idx(plane_idx), .slot_idx(slot_idx),
        .slot_live(slot_live), .line_start(line_start)
    );

    // Reference clock position in the line.
    always @(posedge clk) begin
        if (!rst_n) mcyc <= 0;
        else        mcyc <= (mcyc == 454) ? 0 : mcyc + 1;
        ticks <= ticks + 1;
        if (ticks > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<=150000", ticks);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cyc %0d: act=%0d exp=%0d", tag, mcyc, act, exp);
        end
    endtask

    // Behavioural expectation of one clock.
    task automatic model(output logic [7:0] g, output int ch, output int pl, output string tag);
        int s = mcyc / 2;
        g = 0; ch = 0; pl = 0; tag = "R9";
        if (mcyc >= 452) begin
            g[0] = req_cpu; tag = "R2";
            return;
        end
        if (bpl_en && s >= win_start && s < win_stop) begin
            int off = s - win_start;
            int p;
            if (hires) p = off % 4;
            else p = ((off % 8) % 2 == 1) ? (off % 8) / 2 : 4 + (off % 8) / 2;
            if (p < planes) begin
                g[7] = 1; pl = p; tag = hires ? "R6" : "R7";
                return;
            end
        end
        begin
            int cls = -1, o = 0;
            if (s >= 1 && s <= 7 && s % 2 == 1)        begin cls = 3; o = (s - 1) / 2; end
            else if (s >= 9 && s <= 11)               begin cls = 4; o = s - 9; end
            else if (s >= 13 && s <= 19 && s % 2 == 1) begin cls = 5; o = (s - 13) / 2; end
            else if (s >= 21 && s <= 51 && s % 2 == 1) begin cls = 6; o = (s - 21) / 2; end
            if (cls >= 0) begin
                bit rq = (cls == 3) ? req_refresh : (cls == 4) ? req_disk :
                         (cls == 5) ? req_audio : req_sprite;
                if (rq) begin g[cls] = 1; ch = o; tag = "R4"; return; end
                tag = "R5";
            end
        end
        if (req_dlist) g[2] = 1;
        else if (req_blit) g[1] = 1;
        else g[0] = req_cpu;
    endtask

    task automatic step();
        logic [7:0] eg; int ech, epl; string tag;
        @(negedge clk);
        if (rnd) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            {req_refresh, req_disk, req_audio, req_sprite, req_dlist, req_blit, req_cpu} = lfsr[6:0];
        end
        #1;
        model(eg, ech, epl, tag);
        chk(slot_idx == 8'(mcyc / 2), "R1 slot_idx", slot_idx, mcyc / 2);
        chk(line_start == (mcyc == 0), "R1 line_start", line_start, mcyc == 0);
        chk(slot_live == (mcyc < 452), "R2 slot_live", slot_live, mcyc < 452);
        chk($countones(grant) <= 1, "R3 onehot", grant, eg);
        chk(grant == eg, {tag, " grant"}, grant, eg);
        chk(chan_idx == 4'(ech), "R4 chan_idx", chan_idx, ech);
        chk(plane_idx == 3'(epl), {tag, " plane_idx"}, plane_idx, epl);
        if (counting) begin
            if (mcyc < 452 && mcyc % 2 == 0)
                for (int b = 0; b < 8; b++) cnt[b] += grant[b];
            if (mcyc >= 452) tail_cpu += grant[0];
        end
    endtask

    task automatic run_line();
        while (mcyc != 454) step();
        for (int b = 0; b < 8; b++) cnt[b] = 0;
        tail_cpu = 0;
        counting = 1;
        for (int i = 0; i < 455; i++) step();
        counting = 0;
    endtask

    task automatic set_fixed(input bit on, input bit dl, input bit bl, input bit cp);
        req_refresh = on; req_disk = on; req_audio = on; req_sprite = on;
        req_dlist = dl; req_blit = bl; req_cpu = cp;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(slot_idx == 0, "R11 reset slot", slot_idx, 0);
        chk(line_start == 1, "R11 reset line_start", line_start, 1);
        chk(grant == 0, "R11 reset grant", grant, 0);
        @(negedge clk); rst_n = 1'b1;

        // Fixed channels only, CPU takes the rest.
        set_fixed(1, 0, 0, 1); bpl_en = 0;
        run_line();
        chk(cnt[3] == 4, "R4 refresh count", cnt[3], 4);
        chk(cnt[4] == 3, "R4 disk count", cnt[4], 3);
        chk(cnt[5] == 4, "R4 audio count", cnt[5], 4);
        chk(cnt[6] == 16, "R4 sprite count", cnt[6], 16);
        chk(cnt[0] == 199, "R9 cpu count", cnt[0], 199);
        chk(tail_cpu == 3, "R2 tail cpu", tail_cpu, 3);

        // High resolution, 4 planes, 160-slot window.
        bpl_en = 1; hires = 1; planes = 4; win_start = 60; win_stop = 220;
        run_line();
        chk(cnt[7] == 160, "R10 hires bpl count", cnt[7], 160);
        chk(cnt[0] == 39, "R10 hires cpu count", cnt[0], 39);

        // Low resolution, 4 planes.
        hires = 0; win_start = 56; win_stop = 216;
        run_line();
        chk(cnt[7] == 80, "R10 lowres bpl count", cnt[7], 80);
        chk(cnt[0] == 119, "R7 lowres cpu count", cnt[0], 119);

        // Low resolution, 6 planes.
        planes = 6;
        run_line();
        chk(cnt[7] == 120, "R7 lowres6 bpl count", cnt[7], 120);

        // Fixed owners idle: slots fall to the blitter.
        bpl_en = 0; set_fixed(0, 0, 1, 1);
        run_line();
        chk(cnt[1] == 226, "R5 blit count", cnt[1], 226);
        chk(cnt[0] == 0, "R9 cpu starved", cnt[0], 0);

        // Display-list over blitter.
        set_fixed(0, 1, 1, 1);
        run_line();
        chk(cnt[2] == 226, "R9 dlist count", cnt[2], 226);

        // Window over sprite slots, 2 planes high resolution.
        set_fixed(1, 0, 0, 1); bpl_en = 1; hires = 1; planes = 2;
        win_start = 40; win_stop = 200;
        run_line();
        chk(cnt[7] == 80, "R8 bpl count", cnt[7], 80);
        chk(cnt[6] == 13, "R8 sprite count", cnt[6], 13);

        // Pseudo-random requests.
        hires = 0; planes = 5; win_start = 80; win_stop = 200; rnd = 1;
        run_line();
        run_line();
        hires = 1; planes = 3;
        run_line();
        rnd = 0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule